// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger Detector

This block watches a vector of already-synchronised input pins and decides, pin by pin, whether an interrupt condition exists. Each pin can be armed for any mix of four triggers: a rising edge, a falling edge, a high level and a low level. Edges are found by comparing each sampled level with a registered copy of the level seen one clock earlier. The trigger result of every pin is then qualified by two bit-aligned masks: an enable mask and a status mask. Bit i of each mask belongs to pin i.

The qualified result is registered as a pending vector. A single-cycle pulse goes toward the host whenever that vector changes from empty to non-empty, so the host side can treat it as a rising-edge request. During reset the stored previous level keeps loading the live pin levels, so pins that are already high when reset is released do not count as edges. Turning pending bits into host interrupt numbers belongs to logic outside this block. There is no data stream here; every port is a plain control or status signal sampled on each clock.

Top module: `pin_trigger_detect`

## Requirements
- R1: While `rst_n` is low, `pend` and `host_pulse` are 0 and the stored previous level follows `pin_lvl`. In the first cycle after reset, a pin whose level has not changed shows no edge.
- R2: A pin with its `rise_en` bit set, enabled and with status set, becomes pending when its level is sampled 1 and the sample one clock earlier was 0.
- R3: A pin with its `fall_en` bit set, enabled and with status set, becomes pending when its level is sampled 0 and the sample one clock earlier was 1.
- R4: A pin with `high_en` set (or `low_en` set) is pending on every evaluation in which its sampled level is 1 (or 0), whatever the previous level.
- R5: The trigger terms of a pin are ORed together. A pin whose four trigger bits are all 0 never becomes pending, whatever its enable and status bits.
- R6: Bit i of `pend` can be 1 only if bit i of `irq_en` and bit i of `irq_stat` were both 1 at the sampling edge.
- R7: `pend` is registered. It reflects the inputs sampled at the most recent rising clock edge and holds until the next edge.
- R8: `host_pulse` is 1 for exactly the cycles in which `pend` is non-zero and was zero in the cycle before. It stays low while `pend` stays non-zero.
- R9: The stored previous level updates on every clock edge, whatever the masks. An edge seen while a pin is disabled is consumed, and enabling that pin later does not report it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | N_PINS | Synchronised pin levels |
| rise_en | input | N_PINS | Per-pin rising-edge trigger select |
| fall_en | input | N_PINS | Per-pin falling-edge trigger select |
| high_en | input | N_PINS | Per-pin high-level trigger select |
| low_en | input | N_PINS | Per-pin low-level trigger select |
| irq_en | input | N_PINS | Per-pin interrupt enable |
| irq_stat | input | N_PINS | Per-pin status qualifier |
| pend | output | N_PINS | Registered pending vector |
| host_pulse | output | 1 | One-cycle pulse when the pending set becomes non-empty |

## Verification
Two things can happen in the same cycle. A new trigger can hit one pin while another pin is already pending, and a single pin can meet both an edge term and a level term. The randomized sweep creates both situations constantly on a four-pin configuration. Its reference model computes the expected pending vector with plain bit arithmetic and expects a pulse only when the previous expected vector was empty. Directed cases cover one pin held level-pending while a second pin's edge arrives; there the pending vector must widen with no second pulse.

// File: rtl/trig_pkg.sv
package trig_pkg;
  parameter int unsigned TRIG_DEFAULT_PINS = 8;

  typedef struct packed {
    logic rise;
    logic fall;
    logic high;
    logic low;
  } trig_sel_t;
endpackage

// File: rtl/trig_prev_level.sv
module trig_prev_level #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] prev_q
);
  // The previous level loads the live level during reset, so a pin that is
  // already high at reset release is not seen as an edge. After reset it
  // updates on every edge, whatever the masks (R9).
  always_ff @(posedge clk) begin
    prev_q <= lvl;
  end

  AST_PREV_TRACKS: assert property (@(posedge clk) 1'b1 |=> (prev_q == $past(lvl))); // R9
endmodule

// File: rtl/trig_pin_eval.sv
module trig_pin_eval
  import trig_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         [W-1:0] lvl,
  input  logic         [W-1:0] prev,
  input  trig_sel_t    [W-1:0] sel,
  input  logic         [W-1:0] en,
  input  logic         [W-1:0] stat,
  output logic         [W-1:0] hit
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic moved;
    logic edge_term;
    logic level_term;
    always_comb begin
      moved      = lvl[i] ^ prev[i];
      edge_term  = moved & ((sel[i].rise & lvl[i]) | (sel[i].fall & ~lvl[i]));
      level_term = (sel[i].high & lvl[i]) | (sel[i].low & ~lvl[i]);
      hit[i]     = (edge_term | level_term) & en[i] & stat[i];
    end
  end
endmodule

// File: rtl/trig_host_pulse.sv
module trig_host_pulse #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit,
  output logic [W-1:0] pend_q,
  output logic         pulse_q
);
  logic any_now;
  logic any_was;

  always_comb begin
    any_now = |hit;
    any_was = |pend_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      pend_q  <= hit;
      pulse_q <= any_now & ~any_was;
    end
  end

  AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> ((pend_q != '0) && ($past(pend_q) == '0))); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> ((pend_q == '0) && !pulse_q)); // R1
endmodule

// File: rtl/pin_trigger_detect.sv
module pin_trigger_detect
  import trig_pkg::*;
#(
  parameter int unsigned N_PINS = TRIG_DEFAULT_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_lvl,
  input  logic [N_PINS-1:0] rise_en,
  input  logic [N_PINS-1:0] fall_en,
  input  logic [N_PINS-1:0] high_en,
  input  logic [N_PINS-1:0] low_en,
  input  logic [N_PINS-1:0] irq_en,
  input  logic [N_PINS-1:0] irq_stat,
  output logic [N_PINS-1:0] pend,
  output logic              host_pulse
);
  logic      [N_PINS-1:0] prev_lvl;
  logic      [N_PINS-1:0] hit;
  trig_sel_t [N_PINS-1:0] sel;

  for (genvar i = 0; i < N_PINS; i++) begin : g_sel
    assign sel[i] = '{rise: rise_en[i], fall: fall_en[i],
                      high: high_en[i], low: low_en[i]};
  end

  trig_prev_level #(.W(N_PINS)) u_prev (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (pin_lvl),
    .prev_q (prev_lvl)
  );

  trig_pin_eval #(.W(N_PINS)) u_eval (
    .lvl  (pin_lvl),
    .prev (prev_lvl),
    .sel  (sel),
    .en   (irq_en),
    .stat (irq_stat),
    .hit  (hit)
  );

  trig_host_pulse #(.W(N_PINS)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .pend_q  (pend),
    .pulse_q (host_pulse)
  );

  AST_PEND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(irq_en & irq_stat)) == '0)); // R6
  AST_NO_TRIGGER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(rise_en | fall_en | high_en | low_en)) == '0)); // R5
endmodule

// File: tb/tb_pin_trigger_detect.sv
`timescale 1ns/1ps
module tb_pin_trigger_detect;
  localparam int unsigned N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_lvl = '0, rise_en = '0, fall_en = '0, high_en = '0, low_en = '0;
  logic [N-1:0] irq_en = '0, irq_stat = '0;
  logic [N-1:0] pend;
  logic         host_pulse;

  int unsigned checks = 0;
  int unsigned fails = 0;
  logic [N-1:0] prev_m = '0;
  logic [N-1:0] pend_m = '0;

  always #2 clk = ~clk;

  pin_trigger_detect #(.N_PINS(N)) dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .rise_en(rise_en),
    .fall_en(fall_en), .high_en(high_en), .low_en(low_en),
    .irq_en(irq_en), .irq_stat(irq_stat), .pend(pend), .host_pulse(host_pulse)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive at the falling edge, evaluate at the rising edge, sample 1 ns later.
  task automatic step(input logic [N-1:0] l, input logic [N-1:0] r, input logic [N-1:0] f,
                      input logic [N-1:0] h, input logic [N-1:0] lo,
                      input logic [N-1:0] e, input logic [N-1:0] s, input string req);
    logic [N-1:0] exp;
    logic         exp_pulse;
    @(negedge clk);
    pin_lvl = l; rise_en = r; fall_en = f; high_en = h; low_en = lo; irq_en = e; irq_stat = s;
    exp = ((l ^ prev_m) & ((f & ~l) | (r & l)) | (h & l) | (lo & ~l)) & e & s;
    exp_pulse = (exp != '0) && (pend_m == '0);
    @(posedge clk);
    #1;
    chk({req, " pend"}, pend, exp);
    chk({req, " pulse"}, {{(N-1){1'b0}}, host_pulse}, {{(N-1){1'b0}}, exp_pulse});
    prev_m = l;
    pend_m = exp;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - (fails > checks ? checks : fails) , checks + 1);
    $finish;
  end

  initial begin
    // R1: reset with pins high and every trigger armed
    pin_lvl = 4'b1011; rise_en = '1; fall_en = '1; irq_en = '1; irq_stat = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pend", pend, '0);
    chk("R1 reset pulse", {3'b0, host_pulse}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    prev_m = 4'b1011;
    pend_m = '0;
    // R1: first cycle after reset, unchanged levels give no edge
    step(4'b1011, '1, '1, '0, '0, '1, '1, "R1 no false edge");
    // R2: rising edge on pin 0, then held high clears it
    step(4'b0000, 4'b0001, '0, '0, '0, '1, '1, "R3 fall unarmed");
    step(4'b0001, 4'b0001, '0, '0, '0, '1, '1, "R2 rise");
    step(4'b0001, 4'b0001, '0, '0, '0, '1, '1, "R2 R7 held");
    // R3: falling edge on pin 1
    step(4'b0011, '0, 4'b0010, '0, '0, '1, '1, "R3 setup");
    step(4'b0001, '0, 4'b0010, '0, '0, '1, '1, "R3 fall");
    // R4: level high on pin 2 stays pending; pin 3 edge arrives without a second pulse (R8)
    step(4'b0100, 4'b1000, '0, 4'b0100, '0, '1, '1, "R4 high");
    step(4'b1100, 4'b1000, '0, 4'b0100, '0, '1, '1, "R8 widen no pulse");
    step(4'b0100, 4'b1000, '0, 4'b0100, 4'b0010, '1, '1, "R4 low");
    // R5: no trigger bits, toggling pins, fully enabled
    step(4'b1010, '0, '0, '0, '0, '1, '1, "R5 unarmed");
    step(4'b0101, '0, '0, '0, '0, '1, '1, "R5 unarmed");
    // R9: edge while disabled is consumed
    step(4'b1111, '1, '0, '0, '0, '0, '1, "R6 disabled");
    step(4'b1111, '1, '0, '0, '0, '1, '1, "R9 consumed");
    // R6: status mask gating
    step(4'b0000, '0, '1, '0, '0, '1, 4'b0101, "R6 status");
    // Sweep across all inputs on the small configuration
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      step(a[3:0], a[7:4], a[11:8], a[15:12] & b[3:0], a[19:16] & b[7:4],
           a[23:20] | b[11:8], a[27:24] | b[15:12], "R2 R3 R4 R5 R6 R7 R8 sweep");
    end
    // R1: reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 reset again", pend, '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule